// File: doc/BRIEF.md
# Encoded-edge boundary converter

This block sits at the border between ordinary single-bit logic running on the grid clock and a sub-cycle edge encoding. In that encoding each grid cycle is described by a start level plus a small set of transition slots. Each slot holds a valid flag and a quantized offset inside the cycle. The offset width is a parameter, so the timing resolution can be traded against bus width.

The block has two independent halves. The entry half turns a plain bit into the encoding. It compares the bit with the level it held at the previous rising edge. A change gives a single transition at offset zero. No change gives a steady coding at the current level.

The exit half works on an incoming encoded cycle. It first cleans out transition pairs that sit closer together than a minimum pulse width. It then reduces the cycle to the level the signal has at its end. A parameter decides when that level reaches the plain output: combinationally, on the next falling grid-clock edge, or on the next rising grid-clock edge.

Top module: `edge_boundary_conv`

## Requirements
- R1: When `din` differs from the stored previous level, `enc_lvl_o` equals the stored previous level. Slot 0 is valid with offset 0, and every other slot is invalid. Slot i's offset sits at bits [i*OFS_W +: OFS_W] of each offset bus, and slot i's valid flag is bit i of each valid mask.
- R2: When `din` equals the stored previous level, `enc_lvl_o` equals `din` and no slot is valid.
- R3: The stored previous level is 0 while reset is applied and for the synchronizer cycles after release. After that it takes `din` at every rising edge of `clk`.
- R4: The valid slots of the incoming cycle are scanned in ascending slot index, skipping invalid slots. A transition is compared with the previous valid transition, but only if that previous transition is still kept. The two are removed together if the later offset minus the earlier one is less than MIN_W, or if the two offsets are equal. `clean_vld_o` is the valid mask that remains after this scan.
- R5: The reduced level is `enc_lvl_i` XOR the parity of the bits set in `clean_vld_o`.
- R6: With DLV_MODE = 0, `dout` follows the reduced level combinationally within the same cycle.
- R7: With DLV_MODE = 1, `dout` takes the reduced level at each falling edge of `clk` and holds it until the next falling edge.
- R8: With DLV_MODE = 2, `dout` takes the reduced level at each rising edge of `clk` and holds it until the next rising edge.
- R9: In modes 1 and 2, `dout` is 0 while reset is applied. Reset (`rst_n` low) asserts asynchronously and is released synchronously, two rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grid clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Plain single-bit input |
| enc_lvl_o | output | 1 | Start level of the encoded form of `din` |
| enc_vld_o | output | NTR | Slot valid mask of the encoded form of `din` |
| enc_ofs_o | output | NTR*OFS_W | Slot offsets of the encoded form of `din` |
| enc_lvl_i | input | 1 | Start level of the incoming encoded cycle |
| enc_vld_i | input | NTR | Slot valid mask of the incoming encoded cycle |
| enc_ofs_i | input | NTR*OFS_W | Slot offsets of the incoming encoded cycle |
| clean_vld_o | output | NTR | Valid mask left after minimum-pulse cleaning |
| dout | output | 1 | Reduced plain output, delivered per DLV_MODE |

## Verification
The bench builds three copies with NTR = 4, OFS_W = 6 and MIN_W = 4, one for each of DLV_MODE 0, 1 and 2. All three share the same stimulus, so the combinational, falling-edge and rising-edge deliveries are compared on identical cycles.

Four slots are enough to reach several cases: a removed pair followed by a kept transition, a gap exactly at the threshold, equal offsets, and invalid slots lying between valid ones. The offset width is large enough that random sorted offsets land on both sides of the threshold.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int unsigned DLV_COMB = 0;
  localparam int unsigned DLV_FALL = 1;
  localparam int unsigned DLV_RISE = 2;
endpackage

// File: rtl/ebc_rst_sync.sv
module ebc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ebc_in_coder.sv
module ebc_in_coder #(
  parameter int unsigned NTR   = 4,
  parameter int unsigned OFS_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_sync_n,
  input  logic                 din,
  output logic                 enc_lvl,
  output logic [NTR-1:0]       enc_vld,
  output logic [NTR*OFS_W-1:0] enc_ofs
);
  logic prev_q;
  logic prev_d;
  logic prev_en;
  logic chg;

  always_comb begin
    chg     = din ^ prev_q;
    prev_en = 1'b1;
    prev_d  = din;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  prev_q <= 1'b0;
    else if (prev_en) prev_q <= prev_d;
  end

  always_comb begin
    enc_lvl    = prev_q;
    enc_vld    = '0;
    enc_vld[0] = chg;
    enc_ofs    = '0;
  end

  AST_EDGE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    enc_vld[0] |-> (enc_lvl != din)); // R1
  AST_STEADY_LEVEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enc_vld == '0) |-> (enc_lvl == din)); // R2
endmodule

// File: rtl/ebc_pulse_filter.sv
module ebc_pulse_filter #(
  parameter int unsigned NTR   = 4,
  parameter int unsigned OFS_W = 6,
  parameter int unsigned MIN_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_sync_n,
  input  logic [NTR-1:0]       vld_i,
  input  logic [NTR*OFS_W-1:0] ofs_i,
  output logic [NTR-1:0]       vld_o
);
  localparam int unsigned IDX_W = (NTR > 1) ? $clog2(NTR) : 1;

  logic [NTR-1:0]   keep;
  logic             have_p;
  logic [OFS_W-1:0] pofs;
  logic [IDX_W-1:0] pidx;
  logic [OFS_W-1:0] cur;
  logic [OFS_W-1:0] dif;
  logic             close;

  always_comb begin
    keep   = vld_i;
    have_p = 1'b0;
    pofs   = '0;
    pidx   = '0;
    cur    = '0;
    dif    = '0;
    close  = 1'b0;
    for (int unsigned i = 0; i < NTR; i++) begin
      cur   = ofs_i[i*OFS_W +: OFS_W];
      dif   = cur - pofs;
      close = (32'(dif) < MIN_W) || (cur == pofs);
      if (vld_i[i]) begin
        if (have_p && close) begin
          keep[i]    = 1'b0;
          keep[pidx] = 1'b0;
          have_p     = 1'b0;
        end else begin
          have_p = 1'b1;
          pofs   = cur;
          pidx   = IDX_W'(i);
        end
      end
    end
    vld_o = keep;
  end

  AST_CLEAN_SUBSET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((vld_o & ~vld_i) == '0)); // R4
  AST_PARITY_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (($countones(vld_o) % 2) == ($countones(vld_i) % 2))); // R5
endmodule

// File: rtl/ebc_reducer.sv
module ebc_reducer #(
  parameter int unsigned NTR      = 4,
  parameter int unsigned DLV_MODE = ebc_pkg::DLV_RISE
) (
  input  logic           clk,
  input  logic           rst_sync_n,
  input  logic           lvl_i,
  input  logic [NTR-1:0] vld_i,
  output logic           dout
);
  logic fin;

  always_comb fin = lvl_i ^ (^vld_i);

  if (DLV_MODE == ebc_pkg::DLV_COMB) begin : g_comb
    assign dout = fin;
  end else if (DLV_MODE == ebc_pkg::DLV_FALL) begin : g_fall
    logic q;
    always_ff @(negedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) q <= 1'b0;
      else             q <= fin;
    end
    assign dout = q;
  end else begin : g_rise
    logic q;
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) q <= 1'b0;
      else             q <= fin;
    end
    assign dout = q;
  end
endmodule

// File: rtl/edge_boundary_conv.sv
module edge_boundary_conv #(
  parameter int unsigned NTR      = 4,
  parameter int unsigned OFS_W    = 6,
  parameter int unsigned MIN_W    = 4,
  parameter int unsigned DLV_MODE = ebc_pkg::DLV_RISE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din,
  output logic                 enc_lvl_o,
  output logic [NTR-1:0]       enc_vld_o,
  output logic [NTR*OFS_W-1:0] enc_ofs_o,
  input  logic                 enc_lvl_i,
  input  logic [NTR-1:0]       enc_vld_i,
  input  logic [NTR*OFS_W-1:0] enc_ofs_i,
  output logic [NTR-1:0]       clean_vld_o,
  output logic                 dout
);
  logic rst_sync_n;

  ebc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ebc_in_coder #(.NTR(NTR), .OFS_W(OFS_W)) u_coder (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .din        (din),
    .enc_lvl    (enc_lvl_o),
    .enc_vld    (enc_vld_o),
    .enc_ofs    (enc_ofs_o)
  );

  ebc_pulse_filter #(.NTR(NTR), .OFS_W(OFS_W), .MIN_W(MIN_W)) u_filt (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .vld_i      (enc_vld_i),
    .ofs_i      (enc_ofs_i),
    .vld_o      (clean_vld_o)
  );

  ebc_reducer #(.NTR(NTR), .DLV_MODE(DLV_MODE)) u_red (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .lvl_i      (enc_lvl_i),
    .vld_i      (clean_vld_o),
    .dout       (dout)
  );

  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(enc_vld_o) <= 1)); // R1

  if (DLV_MODE == ebc_pkg::DLV_RISE) begin : g_chk_rise
    AST_RISE_DELIVER: assert property (@(posedge clk) disable iff (!rst_sync_n)
      1'b1 |=> (dout == $past(enc_lvl_i ^ (^enc_vld_i)))); // R8
  end else if (DLV_MODE == ebc_pkg::DLV_FALL) begin : g_chk_fall
    AST_FALL_DELIVER: assert property (@(negedge clk) disable iff (!rst_sync_n)
      1'b1 |=> (dout == $past(enc_lvl_i ^ (^enc_vld_i)))); // R7
  end
endmodule

// File: tb/edge_boundary_conv_bench.sv
module edge_boundary_conv_bench;
  localparam int unsigned NTR   = 4;
  localparam int unsigned OFS_W = 6;
  localparam int unsigned MIN_W = 4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 din;
  logic                 lvl_i;
  logic [NTR-1:0]       vld_i;
  logic [NTR*OFS_W-1:0] ofs_i;

  logic                 e_lvl, e_lvl0, e_lvl1;
  logic [NTR-1:0]       e_vld, e_vld0, e_vld1;
  logic [NTR*OFS_W-1:0] e_ofs, e_ofs0, e_ofs1;
  logic [NTR-1:0]       cln, cln0, cln1;
  logic                 dout2, dout0, dout1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic prev_m;

  always #10 clk = ~clk;

  edge_boundary_conv #(.NTR(NTR), .OFS_W(OFS_W), .MIN_W(MIN_W), .DLV_MODE(2)) u_edge_boundary_conv (
    .clk(clk), .rst_n(rst_n), .din(din), .enc_lvl_o(e_lvl), .enc_vld_o(e_vld),
    .enc_ofs_o(e_ofs), .enc_lvl_i(lvl_i), .enc_vld_i(vld_i), .enc_ofs_i(ofs_i),
    .clean_vld_o(cln), .dout(dout2));

  edge_boundary_conv #(.NTR(NTR), .OFS_W(OFS_W), .MIN_W(MIN_W), .DLV_MODE(0)) u_edge_boundary_conv_comb (
    .clk(clk), .rst_n(rst_n), .din(din), .enc_lvl_o(e_lvl0), .enc_vld_o(e_vld0),
    .enc_ofs_o(e_ofs0), .enc_lvl_i(lvl_i), .enc_vld_i(vld_i), .enc_ofs_i(ofs_i),
    .clean_vld_o(cln0), .dout(dout0));

  edge_boundary_conv #(.NTR(NTR), .OFS_W(OFS_W), .MIN_W(MIN_W), .DLV_MODE(1)) u_edge_boundary_conv_fall (
    .clk(clk), .rst_n(rst_n), .din(din), .enc_lvl_o(e_lvl1), .enc_vld_o(e_vld1),
    .enc_ofs_o(e_ofs1), .enc_lvl_i(lvl_i), .enc_vld_i(vld_i), .enc_ofs_i(ofs_i),
    .clean_vld_o(cln1), .dout(dout1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected cleaned mask per the pairwise minimum-gap rule
  function automatic logic [NTR-1:0] exp_clean(input logic [NTR-1:0] v,
                                               input logic [NTR*OFS_W-1:0] o);
    logic [NTR-1:0] k = v;
    int last = -1;
    for (int i = 0; i < NTR; i++) begin
      if (v[i]) begin
        if (last >= 0) begin
          int a = int'(o[last*OFS_W +: OFS_W]);
          int b = int'(o[i*OFS_W +: OFS_W]);
          if ((b - a) < int'(MIN_W) || a == b) begin
            k[i] = 1'b0; k[last] = 1'b0; last = -1;
          end else last = i;
        end else last = i;
      end
    end
    return k;
  endfunction

  function automatic logic [NTR*OFS_W-1:0] pack4(input int a, input int b, input int c, input int d);
    return {OFS_W'(d), OFS_W'(c), OFS_W'(b), OFS_W'(a)};
  endfunction

  task automatic step(input logic d, input logic l, input logic [NTR-1:0] v,
                      input logic [NTR*OFS_W-1:0] o);
    logic [NTR-1:0] ec;
    logic fin;
    @(posedge clk); #2;
    din = d; lvl_i = l; vld_i = v; ofs_i = o;
    ec  = exp_clean(v, o);
    fin = l ^ (^ec);
    #3;
    if (d != prev_m) begin
      chk("R1 lvl", 32'(e_lvl), 32'(prev_m));
      chk("R1 vld", 32'(e_vld), 32'd1);
      chk("R1 ofs", 32'(e_ofs), 32'd0);
    end else begin
      chk("R2 lvl", 32'(e_lvl), 32'(d));
      chk("R2 vld", 32'(e_vld), 32'd0);
    end
    chk("R4 clean", 32'(cln), 32'(ec));
    chk("R5 R6 comb dout", 32'(dout0), 32'(fin));
    #10;
    chk("R7 fall dout", 32'(dout1), 32'(fin));
    @(posedge clk); #1;
    chk("R8 rise dout", 32'(dout2), 32'(fin));
    prev_m = d;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; din = 1'b0; lvl_i = 1'b1; vld_i = '0; ofs_i = '0; prev_m = 1'b0;
    repeat (3) @(posedge clk);
    #2 din = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    // R3 R9: previous level held at 0 through reset, registered outputs low
    chk("R3 reset edge", 32'(e_vld), 32'd1);
    chk("R3 reset lvl", 32'(e_lvl), 32'd0);
    chk("R9 rise dout reset", 32'(dout2), 32'd0);
    chk("R9 fall dout reset", 32'(dout1), 32'd0);
    din = 1'b0;
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 prev_m = 1'b0;

    // directed R4 cases (offsets slot0..slot3)
    step(1'b1, 1'b0, 4'b0011, pack4(10, 13, 0, 0));   // gap 3 removed
    step(1'b1, 1'b0, 4'b0011, pack4(10, 14, 0, 0));   // gap 4 kept
    step(1'b0, 1'b1, 4'b0011, pack4(20, 20, 0, 0));   // equal removed
    step(1'b0, 1'b0, 4'b0111, pack4(0, 1, 2, 0));     // pair then keep
    step(1'b1, 1'b1, 4'b1101, pack4(5, 40, 7, 30));   // hole: 5,7 removed
    step(1'b1, 1'b0, 4'b1111, pack4(0, 10, 11, 12));  // 10,11 removed
    step(1'b0, 1'b1, 4'b0000, pack4(0, 0, 0, 0));     // no edges
    step(1'b0, 1'b0, 4'b0001, pack4(63, 0, 0, 0));    // single late edge

    for (int n = 0; n < 300; n++) begin
      logic [NTR-1:0] v = NTR'($urandom);
      int o0 = int'($urandom_range(0, 15));
      int o1 = o0 + int'($urandom_range(0, 7));
      int o2 = o1 + int'($urandom_range(0, 7));
      int o3 = o2 + int'($urandom_range(0, 7));
      step(1'($urandom), 1'($urandom), v, pack4(o0, o1, o2, o3));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule